// File: doc/BRIEF.md
# Dual-Clock RAM with Reset Fill

This block is a two-port storage array. One port only writes and runs on its own write clock. The other port only reads and runs on a separate read clock. The two clocks need no fixed phase or frequency relation. A single asynchronous active-low reset serves both sides. While that reset is low, the whole array takes on the value present at the write data input. Software-visible memories can therefore start from a known, chosen pattern rather than from zero, and no sweep over the array is needed after reset.

The fill does not load every word. The write side keeps one fill register and one "written" flag per word. The reset clears all flags at once. A read of a word whose flag is clear returns the fill register.

Both ports are always ready: there is no back-pressure. A port acts whenever its active-low enable is sampled low at its own clock edge. A read is registered, so the word appears on the output after the read clock edge that sampled the request. The output then holds until the next enabled read.

Two cases leave the result undefined:
- a write attempted while reset is low;
- a read and a write to the same address in overlapping cycles.

Top module: `dcram_fill`

## Requirements
- R1: With `arst_n` high, a rising `clk_w` edge that samples `w_en_n` low stores `w_data` into word `w_addr`; a later read of that word returns it.
- R2: A rising `clk_r` edge that samples `r_en_n` low loads word `r_addr` into `r_data` at that edge (one read-clock latency).
- R3: A rising `clk_r` edge that samples `r_en_n` high leaves `r_data` unchanged, whatever `r_addr` does.
- R4: While `arst_n` is low, every word takes the value on `w_data`, provided that value is held across at least one rising `clk_w` edge; after release, any word not yet written reads back that fill value.
- R5: `r_data` goes to zero as soon as `arst_n` falls, without waiting for a clock edge, and stays zero while reset is low.
- R6: A `clk_w` edge with `w_en_n` high changes no word, whatever `w_addr` and `w_data` carry.
- R7: A second write to a word replaces the first value.
- R8: Reads and writes proceed at the same time on unrelated clock periods; a read of one address during a write to a different address returns that address's prior contents, across the full range of `2**ADDR_W` words.
- R9: A later reset refills words that were written before it, so they read back the new fill value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_w | input | 1 | Write-side clock |
| clk_r | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous reset, active low; also triggers the fill |
| w_en_n | input | 1 | Write enable, active low |
| w_addr | input | ADDR_W | Word address for writes |
| w_data | input | DATA_W | Write data; also the fill value while reset is low |
| r_en_n | input | 1 | Read enable, active low |
| r_addr | input | ADDR_W | Word address for reads |
| r_data | output | DATA_W | Registered read data |

## Verification
The two functions that can fall in the same cycle are a write on one clock and a read on the other. The bench starts a write sweep of the upper half of the array and a read sweep of the lower half in parallel threads. The two clocks have unrelated periods, so the edges drift against each other throughout the sweep. Each read is judged against the value that address held before the sweep, and the freshly written half is read back afterwards. Same-address overlap is never provoked, because its result is undefined.

// File: rtl/dcram_pkg.sv
package dcram_pkg;
  // Source chosen for a read: the stored word, or the reset fill value.
  typedef enum logic [0:0] {
    SRC_FILL = 1'b0,
    SRC_WORD = 1'b1
  } rd_src_e;

  function automatic rd_src_e pick_src(input logic written);
    return written ? SRC_WORD : SRC_FILL;
  endfunction
endpackage

// File: rtl/dcram_fill_reg.sv
module dcram_fill_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_w,
  input  logic              arst_n,
  input  logic [DATA_W-1:0] w_data,
  output logic [DATA_W-1:0] fill_q
);
  // Capture the write data on each write clock edge while reset is held.
  always_ff @(posedge clk_w) begin
    if (!arst_n) fill_q <= w_data;
  end

  AST_FILL_FROZEN: assert property (@(posedge clk_w) disable iff (!arst_n)
    1'b1 |=> $stable(fill_q)); // R4
endmodule

// File: rtl/dcram_store.sv
module dcram_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                           clk_w,
  input  logic                           arst_n,
  input  logic                           w_en_n,
  input  logic [ADDR_W-1:0]              w_addr,
  input  logic [DATA_W-1:0]              w_data,
  output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] words_q,
  output logic [(1<<ADDR_W)-1:0]         written_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign hit[i] = !w_en_n && (w_addr == ADDR_W'(i));

    always_ff @(posedge clk_w or negedge arst_n) begin
      if (!arst_n)     written_q[i] <= 1'b0;
      else if (hit[i]) written_q[i] <= 1'b1;
    end

    always_ff @(posedge clk_w) begin
      if (arst_n && hit[i]) words_q[i] <= w_data;
    end
  end

  AST_WRITE_MARKS_WORD: assert property (@(posedge clk_w) disable iff (!arst_n)
    !w_en_n |=> written_q[$past(w_addr)]); // R1
  AST_FLAGS_ONLY_RISE: assert property (@(posedge clk_w) disable iff (!arst_n)
    1'b1 |=> ($countones(written_q) >= $past($countones(written_q)))); // R9
  AST_IDLE_NO_FLAG_CHANGE: assert property (@(posedge clk_w) disable iff (!arst_n)
    w_en_n |=> $stable(written_q)); // R6
endmodule

// File: rtl/dcram_rd_port.sv
module dcram_rd_port
  import dcram_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                               clk_r,
  input  logic                               arst_n,
  input  logic                               r_en_n,
  input  logic [ADDR_W-1:0]                  r_addr,
  input  logic [(1<<ADDR_W)-1:0][DATA_W-1:0] words_q,
  input  logic [(1<<ADDR_W)-1:0]             written_q,
  input  logic [DATA_W-1:0]                  fill_q,
  output logic [DATA_W-1:0]                  r_data
);
  rd_src_e           src;
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    src      = pick_src(written_q[r_addr]);
    sel_word = (src == SRC_WORD) ? words_q[r_addr] : fill_q;
  end

  always_ff @(posedge clk_r or negedge arst_n) begin
    if (!arst_n)      r_data <= '0;
    else if (!r_en_n) r_data <= sel_word;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_r) disable iff (!arst_n)
    r_en_n |=> $stable(r_data)); // R3
endmodule

// File: rtl/dcram_fill.sv
module dcram_fill #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_w,
  input  logic              clk_r,
  input  logic              arst_n,
  input  logic              w_en_n,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [DATA_W-1:0] w_data,
  input  logic              r_en_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic [DATA_W-1:0] r_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0]             fill_q;
  logic [DEPTH-1:0][DATA_W-1:0]  words_q;
  logic [DEPTH-1:0]              written_q;

  dcram_fill_reg #(.DATA_W(DATA_W)) u_fill (
    .clk_w  (clk_w),
    .arst_n (arst_n),
    .w_data (w_data),
    .fill_q (fill_q)
  );

  dcram_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_w     (clk_w),
    .arst_n    (arst_n),
    .w_en_n    (w_en_n),
    .w_addr    (w_addr),
    .w_data    (w_data),
    .words_q   (words_q),
    .written_q (written_q)
  );

  dcram_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_r     (clk_r),
    .arst_n    (arst_n),
    .r_en_n    (r_en_n),
    .r_addr    (r_addr),
    .words_q   (words_q),
    .written_q (written_q),
    .fill_q    (fill_q),
    .r_data    (r_data)
  );
endmodule

// File: tb/dcram_fill_test.sv
module dcram_fill_test;
  localparam int CLK_PERIOD    = 10;
  localparam int RD_CLK_PERIOD = CLK_PERIOD * 7 / 5;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic clk_w = 1'b0, clk_r = 1'b0, arst_n = 1'b0;
  logic w_en_n = 1'b1, r_en_n = 1'b1;
  logic [AW-1:0] w_addr = '0, r_addr = '0;
  logic [DW-1:0] w_data = '0;
  logic [DW-1:0] r_data;

  logic [DW-1:0] exp_mem [DEPTH];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_w = ~clk_w;
  always #(RD_CLK_PERIOD/2) clk_r = ~clk_r;

  dcram_fill #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_w(clk_w), .clk_r(clk_r), .arst_n(arst_n),
    .w_en_n(w_en_n), .w_addr(w_addr), .w_data(w_data),
    .r_en_n(r_en_n), .r_addr(r_addr), .r_data(r_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    @(negedge clk_w);
    w_addr = AW'(a); w_data = d; w_en_n = 1'b0;
    @(negedge clk_w);
    w_en_n = 1'b1;
    exp_mem[a] = d;
  endtask

  task automatic do_read(input string req, input int a);
    @(negedge clk_r);
    r_addr = AW'(a); r_en_n = 1'b0;
    @(negedge clk_r);
    r_en_n = 1'b1;
    check(req, r_data, exp_mem[a]);
  endtask

  task automatic apply_reset(input logic [DW-1:0] fill);
    @(posedge clk_r);
    #2;
    w_data = fill;
    arst_n = 1'b0;
    #1;
    check("R5 async clear", r_data, '0);
    repeat (3) @(negedge clk_w);
    check("R5 zero during reset", r_data, '0);
    arst_n = 1'b1;
    repeat (2) @(negedge clk_w);
    w_data = ~fill;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = fill;
  endtask

  task automatic t_reset_fill;
    check("R5 reset state", r_data, '0);
    apply_reset(16'hA5C3);
    do_read("R4 fill addr 3", 3);
    do_read("R4 fill addr 15", 15);
    do_read("R4 fill addr 0", 0);
  endtask

  task automatic t_write_read;
    do_write(2, 16'h1234);
    do_write(9, 16'hBEEF);
    do_write(14, 16'h0F0F);
    do_read("R1 addr 2", 2);
    do_read("R2 addr 9", 9);
    do_read("R1 addr 14", 14);
    do_read("R4 unwritten 7", 7);
  endtask

  task automatic t_hold;
    logic [DW-1:0] held;
    do_read("R2 pre-hold", 9);
    held = r_data;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_r);
      r_addr = AW'(k);
    end
    @(negedge clk_r);
    check("R3 hold while idle", r_data, held);
  endtask

  task automatic t_ignored_write;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_w);
      w_addr = 4'd2; w_data = 16'hDEAD + DW'(k); w_en_n = 1'b1;
    end
    @(negedge clk_w);
    do_read("R6 no write when disabled", 2);
  endtask

  task automatic t_overwrite;
    do_write(5, 16'h5555);
    do_write(5, 16'hAAAA);
    do_read("R7 overwrite", 5);
  endtask

  task automatic t_concurrent;
    for (int i = 0; i < DEPTH; i++) do_write(i, DW'(16'h1000 + i * 16'h0111));
    fork
      begin
        for (int i = DEPTH/2; i < DEPTH; i++) do_write(i, DW'(16'hC000 + i * 16'h0013));
      end
      begin
        for (int i = 0; i < DEPTH/2; i++) do_read("R8 read during write", i);
      end
    join
    for (int i = DEPTH/2; i < DEPTH; i++) do_read("R8 upper half", i);
  endtask

  task automatic t_refill;
    apply_reset(16'h3C5A);
    do_read("R9 refill written 5", 5);
    do_read("R9 refill written 12", 12);
    do_write(12, 16'h7777);
    do_read("R1 after refill", 12);
    do_read("R9 refill written 0", 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    #1;
    t_reset_fill();
    t_write_read();
    t_hold();
    t_ignored_write();
    t_overwrite();
    t_concurrent();
    t_refill();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule